// File: doc/BRIEF.md
# I2C Master Receive ACK Sequencer

This block runs the acknowledge and bus-termination decisions of an I2C master that reads bytes from a target. A read is armed by a start strobe that carries the read/write bit of the address byte, the number of bytes to receive and whether this is the final message of a combined transfer. The block then reacts to three bus events from the byte engine: address phase complete, receive buffer holding a byte, and byte transfer finished with the shift register also full.

The block decides when the ACK bit is driven, when the ACK setting moves to the byte after the current one, when a STOP or a repeated START is requested, and when the data register is to be read. It uses a separate path for each message length: none, one, two, and three or more bytes. For long reads it drops ACK early enough that the target receives a NACK on the final byte. The byte engine and the SCL timing live elsewhere.

Top module: `i2c_rx_ack_seq`

## Requirements
- R1: A start strobe is accepted only in idle and only when addr_rw_i is 1 (read). With addr_rw_i at 0 the strobe has no effect, and later bus events produce no output change.
- R2: With a count of 0, the cycle after address-done shows done and one request: stop_req_o if the message is last, restart_req_o otherwise. No read strobe is issued.
- R3: With a count of 1, ack_en_o is low the cycle after address-done. The stop or restart request follows one cycle later. The next receive or transfer-finished event gives one read strobe together with done.
- R4: With a count of 2, the cycle after address-done shows ack_en_o low and pos_sel_o high. Receive-not-empty events are then ignored.
- R5: With a count of 3 or more, ack_en_o is high the cycle after address-done.
- R6: While more than 3 bytes remain, each receive or transfer-finished event gives exactly one read strobe in the next cycle and removes one byte from the remaining count.
- R7: With 3 bytes left, receive events are ignored. A transfer-finished event clears ack_en_o and gives one read strobe.
- R8: With 2 bytes left, a transfer-finished event gives a stop or restart pulse in the next cycle, then read strobes in the two following cycles, with done on the second. pos_sel_o is low when done is shown.
- R9: An error event while a message is active gives done_o and err_o together in the next cycle, with ack_en_o, pos_sel_o and all requests low, and returns to idle. Error events in idle are ignored.
- R10: stop_req_o and restart_req_o are single-cycle pulses and are never high together. A stop is requested only for the last message and a restart only for other messages.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arm a message (one-cycle strobe) |
| addr_rw_i | input | 1 | Read/write bit (LSB of the 8-bit address byte), 1 = read |
| count_i | input | CNT_W | Number of bytes to receive |
| last_i | input | 1 | Message is the last one of the transfer |
| addr_done_i | input | 1 | Address phase complete event |
| rx_ne_i | input | 1 | Receive buffer not empty event |
| btf_i | input | 1 | Byte transfer finished event |
| err_i | input | 1 | Bus error event |
| ack_en_o | output | 1 | Drive ACK on received bytes |
| pos_sel_o | output | 1 | Apply the ACK setting to the following byte |
| stop_req_o | output | 1 | Request STOP (pulse) |
| restart_req_o | output | 1 | Request repeated START (pulse) |
| rd_strobe_o | output | 1 | Read the data register (pulse) |
| done_o | output | 1 | Message finished (pulse) |
| err_o | output | 1 | Finished by abort; valid with done_o |

## Verification
A wrong remaining-count class shows up at the ports within one event. A stray or missing read strobe, an early NACK or an early stop appears in the cycle after the event that the sequencer misjudged. A wrong state after the two-byte tail or after an abort is exposed by the next message: its first output cycle shows a stale ack_en_o or pos_sel_o, or it shows no response to address-done. Random message lengths with random idle gaps between events cover every length class and both the stop and restart terminations.

// File: rtl/i2c_rxs_pkg.sv
package i2c_rxs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ONE_REQ, ST_RUN, ST_RD_A, ST_RD_B
  } rxs_state_e;

  typedef enum logic [2:0] {
    CL_ZERO, CL_ONE, CL_TWO, CL_THREE, CL_MANY
  } cnt_cls_e;

  localparam int unsigned NUM_PULSE  = 5;
  localparam int unsigned PI_STOP    = 0;
  localparam int unsigned PI_RESTART = 1;
  localparam int unsigned PI_READ    = 2;
  localparam int unsigned PI_DONE    = 3;
  localparam int unsigned PI_ERR     = 4;
endpackage

// File: rtl/i2c_rxs_cnt.sv
module i2c_rxs_cnt
  import i2c_rxs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output cnt_cls_e         cls_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  always_comb begin
    if (cnt_q == '0)         cls_o = CL_ZERO;
    else if (cnt_q == ONE)   cls_o = CL_ONE;
    else if (cnt_q == TWO)   cls_o = CL_TWO;
    else if (cnt_q == THREE) cls_o = CL_THREE;
    else                     cls_o = CL_MANY;
  end
endmodule

// File: rtl/i2c_rxs_fsm.sv
module i2c_rxs_fsm
  import i2c_rxs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rd_dir_i,
  input  logic                 last_i,
  input  logic                 addr_done_i,
  input  logic                 rx_ne_i,
  input  logic                 btf_i,
  input  logic                 err_i,
  input  cnt_cls_e             cls_i,
  output logic                 load_o,
  output logic                 dec_o,
  output logic                 ack_set_o,
  output logic                 ack_clr_o,
  output logic                 pos_set_o,
  output logic                 pos_clr_o,
  output logic [NUM_PULSE-1:0] pulse_d_o
);
  rxs_state_e st_q, st_d;
  logic       last_q;
  logic       any_ev;

  assign any_ev = rx_ne_i | btf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_o) last_q <= last_i;
    end
  end

  always_comb begin
    st_d      = st_q;
    load_o    = 1'b0;
    ack_set_o = 1'b0;
    ack_clr_o = 1'b0;
    pos_set_o = 1'b0;
    pos_clr_o = 1'b0;
    pulse_d_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && rd_dir_i) begin
          load_o = 1'b1;
          st_d   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (addr_done_i) begin
          unique case (cls_i)
            CL_ZERO: begin
              pulse_d_o[PI_STOP]    = last_q;
              pulse_d_o[PI_RESTART] = !last_q;
              pulse_d_o[PI_DONE]    = 1'b1;
              pos_clr_o             = 1'b1;
              st_d                  = ST_IDLE;
            end
            CL_ONE: begin
              ack_clr_o = 1'b1;
              st_d      = ST_ONE_REQ;
            end
            CL_TWO: begin
              ack_clr_o = 1'b1;
              pos_set_o = 1'b1;
              st_d      = ST_RUN;
            end
            default: begin
              ack_set_o = 1'b1;
              st_d      = ST_RUN;
            end
          endcase
        end
      end
      ST_ONE_REQ: begin
        // NACK already armed; now request bus termination
        pulse_d_o[PI_STOP]    = last_q;
        pulse_d_o[PI_RESTART] = !last_q;
        st_d                  = ST_RUN;
      end
      ST_RUN: begin
        unique case (cls_i)
          CL_ONE: begin
            if (any_ev) begin
              pulse_d_o[PI_READ] = 1'b1;
              pulse_d_o[PI_DONE] = 1'b1;
              pos_clr_o          = 1'b1;
              st_d               = ST_IDLE;
            end
          end
          CL_TWO: begin
            if (btf_i) begin
              pulse_d_o[PI_STOP]    = last_q;
              pulse_d_o[PI_RESTART] = !last_q;
              st_d                  = ST_RD_A;
            end
          end
          CL_THREE: begin
            if (btf_i) begin
              ack_clr_o          = 1'b1;
              pulse_d_o[PI_READ] = 1'b1;
            end
          end
          CL_MANY: begin
            if (any_ev) pulse_d_o[PI_READ] = 1'b1;
          end
          default: begin
            pulse_d_o[PI_DONE] = 1'b1;
            pos_clr_o          = 1'b1;
            st_d               = ST_IDLE;
          end
        endcase
      end
      ST_RD_A: begin
        pulse_d_o[PI_READ] = 1'b1;
        st_d               = ST_RD_B;
      end
      ST_RD_B: begin
        pulse_d_o[PI_READ] = 1'b1;
        pulse_d_o[PI_DONE] = 1'b1;
        pos_clr_o          = 1'b1;
        st_d               = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    // abort overrides everything while a message is active
    if (st_q != ST_IDLE && err_i) begin
      load_o            = 1'b0;
      ack_set_o         = 1'b0;
      pos_set_o         = 1'b0;
      ack_clr_o         = 1'b1;
      pos_clr_o         = 1'b1;
      pulse_d_o         = '0;
      pulse_d_o[PI_DONE] = 1'b1;
      pulse_d_o[PI_ERR]  = 1'b1;
      st_d              = ST_IDLE;
    end
  end

  assign dec_o = pulse_d_o[PI_READ];
endmodule

// File: rtl/i2c_rxs_out.sv
module i2c_rxs_out
  import i2c_rxs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ack_set_i,
  input  logic                 ack_clr_i,
  input  logic                 pos_set_i,
  input  logic                 pos_clr_i,
  input  logic [NUM_PULSE-1:0] pulse_d_i,
  output logic                 ack_o,
  output logic                 pos_o,
  output logic [NUM_PULSE-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o <= 1'b0;
      pos_o <= 1'b0;
    end else begin
      if (ack_clr_i)      ack_o <= 1'b0;
      else if (ack_set_i) ack_o <= 1'b1;
      if (pos_clr_i)      pos_o <= 1'b0;
      else if (pos_set_i) pos_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[g] <= 1'b0;
      else         pulse_o[g] <= pulse_d_i[g];
    end
  end
endmodule

// File: rtl/i2c_rx_ack_seq.sv
module i2c_rx_ack_seq
  import i2c_rxs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             addr_rw_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             last_i,
  input  logic             addr_done_i,
  input  logic             rx_ne_i,
  input  logic             btf_i,
  input  logic             err_i,
  output logic             ack_en_o,
  output logic             pos_sel_o,
  output logic             stop_req_o,
  output logic             restart_req_o,
  output logic             rd_strobe_o,
  output logic             done_o,
  output logic             err_o
);
  cnt_cls_e             cls;
  logic                 load, dec;
  logic                 ack_set, ack_clr, pos_set, pos_clr;
  logic [NUM_PULSE-1:0] pulse_d, pulse_q;

  i2c_rxs_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (count_i),
    .dec_i      (dec),
    .cls_o      (cls)
  );

  i2c_rxs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rd_dir_i    (addr_rw_i),
    .last_i      (last_i),
    .addr_done_i (addr_done_i),
    .rx_ne_i     (rx_ne_i),
    .btf_i       (btf_i),
    .err_i       (err_i),
    .cls_i       (cls),
    .load_o      (load),
    .dec_o       (dec),
    .ack_set_o   (ack_set),
    .ack_clr_o   (ack_clr),
    .pos_set_o   (pos_set),
    .pos_clr_o   (pos_clr),
    .pulse_d_o   (pulse_d)
  );

  i2c_rxs_out u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_set_i (ack_set),
    .ack_clr_i (ack_clr),
    .pos_set_i (pos_set),
    .pos_clr_i (pos_clr),
    .pulse_d_i (pulse_d),
    .ack_o     (ack_en_o),
    .pos_o     (pos_sel_o),
    .pulse_o   (pulse_q)
  );

  assign stop_req_o    = pulse_q[PI_STOP];
  assign restart_req_o = pulse_q[PI_RESTART];
  assign rd_strobe_o   = pulse_q[PI_READ];
  assign done_o        = pulse_q[PI_DONE];
  assign err_o         = pulse_q[PI_ERR];
endmodule

// File: rtl/i2c_rx_ack_seq_chk.sv
module i2c_rx_ack_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic msg_last_i,
  input logic err_i,
  input logic ack_en_o,
  input logic pos_sel_o,
  input logic stop_req_o,
  input logic restart_req_o,
  input logic rd_strobe_o,
  input logic done_o,
  input logic err_o
);
  p_req_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_req_o && restart_req_o));
  p_stop_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |=> !stop_req_o);
  p_restart_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_req_o |=> !restart_req_o);
  p_stop_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |-> msg_last_i);
  p_restart_not_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_req_o |-> !msg_last_i);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && err_i) |=> (done_o && err_o && !ack_en_o && !pos_sel_o &&
                           !stop_req_o && !restart_req_o && !rd_strobe_o));
  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_pos_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pos_sel_o);
  p_read_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_o |-> !(stop_req_o || restart_req_o));
  p_pos_nack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_sel_o |-> !ack_en_o);
endmodule

bind i2c_rx_ack_seq i2c_rx_ack_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (u_fsm.st_q != i2c_rxs_pkg::ST_IDLE),
  .msg_last_i    (u_fsm.last_q),
  .err_i         (err_i),
  .ack_en_o      (ack_en_o),
  .pos_sel_o     (pos_sel_o),
  .stop_req_o    (stop_req_o),
  .restart_req_o (restart_req_o),
  .rd_strobe_o   (rd_strobe_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/sim_i2c_rx_ack_seq.sv
module sim_i2c_rx_ack_seq;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, rw, last, addr_done, rx_ne, btf, err;
  logic [CNT_W-1:0] count;
  logic ack_en, pos_sel, stop_req, restart_req, rd_strobe, done, err_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit cur_ack = 1'b0;

  always #10 clk = ~clk;

  i2c_rx_ack_seq #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_rw_i(rw),
    .count_i(count), .last_i(last), .addr_done_i(addr_done),
    .rx_ne_i(rx_ne), .btf_i(btf), .err_i(err),
    .ack_en_o(ack_en), .pos_sel_o(pos_sel), .stop_req_o(stop_req),
    .restart_req_o(restart_req), .rd_strobe_o(rd_strobe),
    .done_o(done), .err_o(err_out)
  );

  // {err, done, read, restart, stop, pos, ack}
  function automatic logic [6:0] ev(bit a, bit p, bit s, bit r, bit rd, bit d, bit e);
    return {e, d, rd, r, s, p, a};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] got;
    got = {err_out, done, rd_strobe, restart_req, stop_req, pos_sel, ack_en};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(bit a, bit r, bit b, bit e);
    addr_done = a; rx_ne = r; btf = b; err = e;
    @(negedge clk);
    addr_done = 0; rx_ne = 0; btf = 0; err = 0;
  endtask

  task automatic arm(bit dir, int n, bit lst);
    start = 1; rw = dir; count = CNT_W'(n); last = lst;
    @(negedge clk);
    start = 0;
  endtask

  task automatic gap(string req, bit a, bit p);
    int k;
    k = int'($urandom_range(0, 2));
    for (int i = 0; i < k; i++) begin
      step(0, 0, 0, 0);
      chk(req, ev(a, p, 0, 0, 0, 0, 0));
    end
  endtask

  task automatic run_msg(int n, bit lst);
    int rem;
    bit p;
    arm(1, n, lst);
    chk("R1", ev(cur_ack, 0, 0, 0, 0, 0, 0));
    gap("R1", cur_ack, 0);
    step(1, 0, 0, 0);
    if (n == 0) begin
      chk("R2 R10", ev(cur_ack, 0, lst, !lst, 0, 1, 0));
      return;
    end
    if (n == 1) begin
      chk("R3", ev(0, 0, 0, 0, 0, 0, 0));
      step(0, 0, 0, 0);
      chk("R3 R10", ev(0, 0, lst, !lst, 0, 0, 0));
      gap("R3", 0, 0);
      if ($urandom_range(0, 1) == 1) step(0, 1, 0, 0); else step(0, 0, 1, 0);
      chk("R3", ev(0, 0, 0, 0, 1, 1, 0));
      cur_ack = 0;
      return;
    end
    if (n == 2) begin
      chk("R4", ev(0, 1, 0, 0, 0, 0, 0));
      p = 1;
    end else begin
      chk("R5", ev(1, 0, 0, 0, 0, 0, 0));
      p = 0;
      rem = n;
      while (rem > 3) begin
        gap("R6", 1, 0);
        if ($urandom_range(0, 1) == 1) step(0, 1, 0, 0); else step(0, 0, 1, 0);
        chk("R6", ev(1, 0, 0, 0, 1, 0, 0));
        rem--;
      end
      step(0, 1, 0, 0);
      chk("R7", ev(1, 0, 0, 0, 0, 0, 0));
      gap("R7", 1, 0);
      step(0, 0, 1, 0);
      chk("R7", ev(0, 0, 0, 0, 1, 0, 0));
    end
    step(0, 1, 0, 0);
    chk("R4 R8", ev(0, p, 0, 0, 0, 0, 0));
    gap("R8", 0, p);
    step(0, 0, 1, 0);
    chk("R8 R10", ev(0, p, lst, !lst, 0, 0, 0));
    step(0, 0, 0, 0);
    chk("R8", ev(0, p, 0, 0, 1, 0, 0));
    step(0, 0, 0, 0);
    chk("R8", ev(0, 0, 0, 0, 1, 1, 0));
    step(0, 0, 0, 0);
    chk("R8 R10", ev(0, 0, 0, 0, 0, 0, 0));
    cur_ack = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11: got hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    start = 0; rw = 0; count = '0; last = 0;
    addr_done = 0; rx_ne = 0; btf = 0; err = 0;
    repeat (3) @(negedge clk);
    chk("R11", ev(0, 0, 0, 0, 0, 0, 0));
    rst_n = 1;
    @(negedge clk);
    chk("R11", ev(0, 0, 0, 0, 0, 0, 0));

    // error in idle is ignored
    step(0, 0, 0, 1);
    chk("R9", ev(0, 0, 0, 0, 0, 0, 0));

    // write direction ignored
    arm(0, 3, 1);
    chk("R1", ev(0, 0, 0, 0, 0, 0, 0));
    step(1, 0, 0, 0);
    chk("R1", ev(0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0);
    chk("R1", ev(0, 0, 0, 0, 0, 0, 0));

    // directed lengths, both terminations
    for (int n = 0; n <= 5; n++) begin
      run_msg(n, 1'b1);
      run_msg(n, 1'b0);
    end

    // abort mid message
    arm(1, 6, 1);
    step(1, 0, 0, 0);
    chk("R5", ev(1, 0, 0, 0, 0, 0, 0));
    step(0, 1, 0, 0);
    chk("R6", ev(1, 0, 0, 0, 1, 0, 0));
    step(0, 0, 0, 1);
    chk("R9", ev(0, 0, 0, 0, 0, 1, 1));
    step(1, 0, 0, 0);
    chk("R9", ev(0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0);
    chk("R9", ev(0, 0, 0, 0, 0, 0, 0));

    // abort during a two-byte read with position select set
    arm(1, 2, 0);
    step(1, 0, 0, 0);
    chk("R4", ev(0, 1, 0, 0, 0, 0, 0));
    step(0, 0, 0, 1);
    chk("R9", ev(0, 0, 0, 0, 0, 1, 1));
    cur_ack = 0;

    // random messages
    for (int i = 0; i < 40; i++) begin
      run_msg(int'($urandom_range(0, 12)), bit'($urandom_range(0, 1)));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule